// File: doc/BRIEF.md
# Interleaved Multi-Stream AES-128 Encryption Round Engine

This block encrypts up to N independent 128-bit blocks at once with AES-128, using a single round of logic. The round is cut into N register stages, and each of the N streams occupies one stage slot. Every clock, each stream moves one stage forward. The stream that leaves the last stage wraps back into stage 0. N streams therefore share one round's worth of S-box and MixColumns logic, and the whole batch finishes in about the time one stream would need on an unpipelined round.

Round keys are not expanded here. The engine drives the index of the round that stage 0 is about to apply, and a surrounding key store returns that round key in the same cycle.

The parameter N selects between two stage splits:
- With N = 4, the stages are: input select with key addition; the first S-box half; the second S-box half; ShiftRows with MixColumns.
- With N = 2, the stages are: key addition merged with the first S-box half; the second S-box half merged with ShiftRows and MixColumns.

Each S-box is evaluated in two halves. The first half produces the four candidate outputs selected by the low six input bits, one for each value of the top two bits. The second half picks one candidate using the registered top two bits.

Top module: `aes_mstream`

## Requirements
- R1: While reset is held and after it is released, `ready` is 1, `done` is 0, `ct_vld` is all zero and `ct` is all zero.
- R2: With the round keys of key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff in every slot, every slot returns 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Each slot s returns the AES-128 encryption of its own input block. The input block is `ld_pt[s*128 +: 128]` and the result appears at `ct[s*128 +: 128]`. The first state byte is bits [127:120].
- R4: A batch is accepted at a clock edge where `ld` and `ready` are both 1. `ready` then stays 0 and `done` stays 0 for exactly 11·N cycles. `done` rises after the 11·N-th edge following the accepting edge.
- R5: For each slot, `ct_vld[s]` equals `ld_mask[s]` as captured at acceptance. The `ct` field of a slot whose mask bit is 0 is all zero. A partial batch takes the same number of cycles as a full one.
- R6: `ld`, `ld_mask` and `ld_pt` are ignored while `ready` is 0. The running batch's results are unchanged.
- R7: During busy cycle k of a batch (k counted from 0), `rk_idx` equals k/N rounded down. It covers 0 to 10, and each value is held for N cycles. The round key on `rk_key` is used in that same cycle.
- R8: While idle with `ld` low, `ct` and `ct_vld` hold their values. `ct_vld` clears on the edge that accepts a new batch.
- R9: `done` is high for exactly one cycle, and `ready` is already 1 in that cycle.
- R10: With N = 2, the engine gives the same ciphertexts for slots 0 and 1, with `done` after 22 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load request for a new batch |
| ld_mask | input | N | Which slots carry a block |
| ld_pt | input | N*128 | Plaintext blocks, slot s at bits s*128 upward |
| ready | output | 1 | Engine idle and able to accept a batch |
| rk_idx | output | RW (4) | Round index whose key is needed this cycle |
| rk_key | input | 128 | Round key for `rk_idx`, same cycle |
| ct | output | N*128 | Ciphertext blocks, slot s at bits s*128 upward |
| ct_vld | output | N | Per-slot valid flags for `ct` |
| done | output | 1 | One-cycle pulse when the batch has finished |

## Verification
Some properties are checked on every cycle:
- The round index never decreases within a batch, never jumps by more than one, and never exceeds 10.
- `done` is a single pulse that coincides with `ready`.
- Outputs hold while idle, and the valid flags clear on acceptance.
- The stream tag returning to stage 0 always matches the slot counter.

The remaining properties only the bench scenarios can show:
- The ciphertext values themselves, for the standard vector and for random keys and blocks.
- Per-slot masking.
- The exact cycle count to `done`.
- That a load during a run leaves results untouched.
- That both stage splits agree.

// File: rtl/aes_mstream.sv
`timescale 1ns/1ps
module aes_mstream #(
  parameter int N  = 4,
  parameter int NR = 10,
  localparam int SW = $clog2(N),
  localparam int RW = $clog2(NR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [N-1:0]    ld_mask,
  input  logic [N*128-1:0] ld_pt,
  output logic            ready,
  output logic [RW-1:0]   rk_idx,
  input  logic [127:0]    rk_key,
  output logic [N*128-1:0] ct,
  output logic [N-1:0]    ct_vld,
  output logic            done
);

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] y, t, s;
    y = 8'h01;
    t = x;
    for (int i = 1; i < 8; i++) begin
      t = gm(t, t);
      y = gm(y, t);
    end
    s = y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]} ^ {y[3:0], y[7:4]} ^ 8'h63;
    return s;
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [0:15][3:0][7:0] cands(input logic [127:0] s);
    logic [0:15][7:0] b;
    logic [0:15][3:0][7:0] c;
    b = s;
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 4; k++)
        c[i][k] = sbox({2'(k), b[i][5:0]});
    return c;
  endfunction

  function automatic logic [0:15][1:0] tops(input logic [127:0] s);
    logic [0:15][7:0] b;
    logic [0:15][1:0] h;
    b = s;
    for (int i = 0; i < 16; i++) h[i] = b[i][7:6];
    return h;
  endfunction

  function automatic logic [127:0] pick(input logic [0:15][3:0][7:0] c, input logic [0:15][1:0] h);
    logic [0:15][7:0] o;
    for (int i = 0; i < 16; i++) o[i] = c[i][h[i]];
    return o;
  endfunction

  function automatic logic [127:0] srmc(input logic [127:0] s, input logic mc);
    logic [0:15][7:0] b, o;
    logic [7:0] a0, a1, a2, a3;
    b = s;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[r + 4*c] = b[r + 4*((c + r) % 4)];
    if (mc) begin
      for (int c = 0; c < 4; c++) begin
        a0 = o[4*c]; a1 = o[4*c+1]; a2 = o[4*c+2]; a3 = o[4*c+3];
        o[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        o[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        o[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        o[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    return o;
  endfunction

  logic                 busy;
  logic [SW-1:0]        slot;
  logic [RW-1:0]        rnd;
  logic [N-1:0]         msk;
  logic [N-1:0][127:0]  pt_q, ct_q;
  logic [N-1:0]         fin_t;
  logic [N-1:0][SW-1:0] sid_t;
  logic [127:0]         fb, ak;
  logic [SW-1:0]        osid;
  logic                 wrap;

  assign ready  = !busy;
  assign rk_idx = rnd;
  assign ct     = ct_q;
  assign osid   = sid_t[N-1];
  assign wrap   = slot == SW'(N - 1);
  assign ak     = ((rnd == '0) ? pt_q[slot] : fb) ^ rk_key;

  always_ff @(posedge clk)
    if (ready && ld) pt_q <= ld_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      rnd    <= '0;
      msk    <= '0;
      done   <= 1'b0;
      ct_vld <= '0;
      ct_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ld) begin
          busy   <= 1'b1;
          slot   <= '0;
          rnd    <= '0;
          msk    <= ld_mask;
          ct_vld <= '0;
        end
      end else begin
        slot <= wrap ? '0 : slot + 1'b1;
        if (wrap) rnd <= rnd + 1'b1;
        if (rnd == RW'(NR)) begin
          ct_q[osid]   <= msk[osid] ? ak : '0;
          ct_vld[osid] <= msk[osid];
          if (wrap) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_t <= '0;
      sid_t <= '0;
    end else begin
      fin_t[0] <= rnd == RW'(NR - 1);
      sid_t[0] <= slot;
      for (int j = 1; j < N; j++) begin
        fin_t[j] <= fin_t[j-1];
        sid_t[j] <= sid_t[j-1];
      end
    end
  end

  generate
    if (N == 4) begin : g_four
      logic [127:0]          r0, r2, r3;
      logic [0:15][3:0][7:0] r1c;
      logic [0:15][1:0]      r1h;
      always_ff @(posedge clk) begin
        r0  <= ak;
        r1c <= cands(r0);
        r1h <= tops(r0);
        r2  <= pick(r1c, r1h);
        r3  <= srmc(r2, !fin_t[N-2]);
      end
      assign fb = r3;
    end else begin : g_two
      logic [0:15][3:0][7:0] r0c;
      logic [0:15][1:0]      r0h;
      logic [127:0]          r1;
      always_ff @(posedge clk) begin
        r0c <= cands(ak);
        r0h <= tops(ak);
        r1  <= srmc(pick(r0c, r0h), !fin_t[N-2]);
      end
      assign fb = r1;
    end
  endgenerate

endmodule

// File: rtl/aes_mstream_chk.sv
`timescale 1ns/1ps
module aes_mstream_chk #(
  parameter int N  = 4,
  parameter int NR = 10,
  localparam int SW = $clog2(N),
  localparam int RW = $clog2(NR + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld,
  input logic             ready,
  input logic             done,
  input logic [RW-1:0]    rk_idx,
  input logic [N*128-1:0] ct,
  input logic [N-1:0]     ct_vld,
  input logic             busy,
  input logic [SW-1:0]    slot,
  input logic [RW-1:0]    rnd,
  input logic [SW-1:0]    fb_sid
);

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (ld && ready) |=> !ready);

  // R7
  rk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> (rk_idx == $past(rk_idx) || rk_idx == $past(rk_idx) + 1'b1));

  // R7
  rk_max_chk: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> rk_idx <= RW'(NR));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld) |=> ($stable(ct) && $stable(ct_vld)));

  // R8
  vld_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (ld && ready) |=> ct_vld == '0);

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R9
  done_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ready);

  // R3
  sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rnd != '0) |-> fb_sid == slot);

endmodule

bind aes_mstream aes_mstream_chk #(.N(N), .NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .ready(ready), .done(done),
  .rk_idx(rk_idx), .ct(ct), .ct_vld(ct_vld), .busy(busy),
  .slot(slot), .rnd(rnd), .fb_sid(sid_t[N-1])
);

// File: tb/sim_aes_mstream.sv
`timescale 1ns/1ps
module sim_aes_mstream;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, ld;
  logic [3:0]   m4;
  logic [511:0] pt4;
  logic         rdy0, rdy1, done0, done1;
  logic [3:0]   rkr0, rkr1;
  logic [127:0] rk0, rk1;
  logic [511:0] ct0;
  logic [255:0] ct1;
  logic [3:0]   vld0;
  logic [1:0]   vld1;

  logic [127:0] rkeys [0:10];
  logic [7:0]   sb [0:255];
  int total = 0, bad = 0;

  assign rk0 = (rkr0 <= 4'd10) ? rkeys[rkr0] : '0;
  assign rk1 = (rkr1 <= 4'd10) ? rkeys[rkr1] : '0;

  aes_mstream #(.N(4)) u0 (.clk(clk), .rst_n(rst_n), .ld(ld), .ld_mask(m4), .ld_pt(pt4),
    .ready(rdy0), .rk_idx(rkr0), .rk_key(rk0), .ct(ct0), .ct_vld(vld0), .done(done0));

  aes_mstream #(.N(2)) u1 (.clk(clk), .rst_n(rst_n), .ld(ld), .ld_mask(m4[1:0]), .ld_pt(pt4[255:0]),
    .ready(rdy1), .rk_idx(rkr1), .rk_key(rk1), .ct(ct1), .ct_vld(vld1), .done(done1));

  task automatic chk(input bit ok, input string rq, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] bxt(input logic [7:0] v);
    return (v << 1) ^ ((v & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0, aa = a, bb = b;
    while (bb != 0) begin
      if (bb & 8'h01) acc ^= aa;
      aa = bxt(aa);
      bb = bb >> 1;
    end
    return acc;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0, s;
      for (int y = 1; y < 256; y++)
        if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = s;
    end
  endtask

  task automatic key_expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
        rc = bxt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++) rkeys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] aes_ref(input logic [127:0] pt);
    logic [7:0] st [16], tmp [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) st[i] = pt[127-8*i -: 8] ^ rkeys[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) st[i] = sb[st[i]];
      for (int i = 0; i < 16; i++) tmp[i] = st[(i + 4*(i%4)) % 16];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          st[4*c]   = bmul(2, tmp[4*c]) ^ bmul(3, tmp[4*c+1]) ^ tmp[4*c+2] ^ tmp[4*c+3];
          st[4*c+1] = tmp[4*c] ^ bmul(2, tmp[4*c+1]) ^ bmul(3, tmp[4*c+2]) ^ tmp[4*c+3];
          st[4*c+2] = tmp[4*c] ^ tmp[4*c+1] ^ bmul(2, tmp[4*c+2]) ^ bmul(3, tmp[4*c+3]);
          st[4*c+3] = bmul(3, tmp[4*c]) ^ tmp[4*c+1] ^ tmp[4*c+2] ^ bmul(2, tmp[4*c+3]);
        end else begin
          for (int k = 0; k < 4; k++) st[4*c+k] = tmp[4*c+k];
        end
      end
      for (int i = 0; i < 16; i++) st[i] ^= rkeys[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = st[i];
    return o;
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_batch(input logic [511:0] p, input logic [3:0] m, input int poke, input string rq);
    logic [511:0] e;
    @(negedge clk);
    pt4 = p; m4 = m; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
    for (int j = 0; j <= 45; j++) begin
      if (j < 44) begin
        chk(!rdy0 && !done0, "R4", {rdy0, done0}, 0);
        chk(rkr0 == 4'(j / 4), "R7", rkr0, j / 4);
      end
      if (j == 0) chk(vld0 == 0 && vld1 == 0, "R8", {vld0, vld1}, 0);
      if (j == 44) chk(done0 && rdy0, "R4", {done0, rdy0}, 3);
      if (j == 45) chk(!done0, "R9", done0, 0);
      if (j < 22) begin
        chk(!rdy1 && !done1, "R10", {rdy1, done1}, 0);
        chk(rkr1 == 4'(j / 2), "R7", rkr1, j / 2);
      end
      if (j == 22) chk(done1 && rdy1, "R10", {done1, rdy1}, 3);
      if (j == 23) chk(!done1, "R9", done1, 0);
      if (j == poke) begin
        pt4 = ~p; m4 = 4'hf; ld = 1'b1;
      end else ld = 1'b0;
      @(negedge clk);
    end
    for (int s = 0; s < 4; s++) e[s*128 +: 128] = m[s] ? aes_ref(p[s*128 +: 128]) : '0;
    chk(ct0 == e, rq, ct0, e);
    chk(vld0 == m, "R5", vld0, m);
    chk(ct1 == e[255:0], "R10", ct1, e[255:0]);
    chk(vld1 == m[1:0], "R10", vld1, m[1:0]);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] fpt, fct;
    logic [511:0] p, h0;
    logic [255:0] h1;
    logic [3:0]   hv0;
    logic [1:0]   hv1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ld = 1'b0; m4 = '0; pt4 = '0;
    build_sbox();
    key_expand(128'h000102030405060708090a0b0c0d0e0f);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(rdy0 && rdy1 && !done0 && !done1, "R1", {rdy0, rdy1, done0, done1}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld0 == 0 && vld1 == 0 && ct0 == 0 && ct1 == 0, "R1", {vld0, vld1}, 0);
    chk(rdy0 && !done0, "R1", {rdy0, done0}, 2);

    fpt = 128'h00112233445566778899aabbccddeeff;
    fct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    chk(aes_ref(fpt) == fct, "R2", aes_ref(fpt), fct);
    run_batch({4{fpt}}, 4'hf, -1, "R2");
    chk(ct0 == {4{fct}}, "R2", ct0, {4{fct}});

    p = {r128(), r128(), r128(), r128()};
    run_batch(p, 4'b0101, -1, "R5");
    p = {r128(), r128(), r128(), r128()};
    run_batch(p, 4'b1000, -1, "R5");

    p = {r128(), r128(), r128(), r128()};
    run_batch(p, 4'hf, 7, "R6");

    // R8 hold while idle
    h0 = ct0; h1 = ct1; hv0 = vld0; hv1 = vld1;
    pt4 = ~pt4; m4 = 4'h3;
    repeat (12) @(negedge clk);
    chk(ct0 == h0 && vld0 == hv0, "R8", ct0, h0);
    chk(ct1 == h1 && vld1 == hv1, "R8", ct1, h1);

    for (int b = 0; b < 6; b++) begin
      key_expand(r128());
      p = {r128(), r128(), r128(), r128()};
      run_batch(p, 4'($urandom) | 4'b0001, -1, "R3");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule